// File: doc/BRIEF.md
# Class-Grouped Bus Arbiter with Chained Grants

This block decides which of several bus masters may drive a shared system bus. The masters are sorted into request classes, four by default. Each class presents a single request to the arbiter and receives a single grant from it. The arbiter handles the classes as independent requesters. Inside a class, the grant ripples along a chain of master slots. The first slot on the chain that wants the bus takes the grant, and every slot that does not want it passes the grant on to the next one.

The owning master announces its tenure on a shared bus-busy line. The default release is transaction-based: the owner drops bus-busy when it has finished, and the arbiter then grants the next class on the following edge. The policy between classes is chosen at run time. In fixed mode the highest class index always wins. In rotating mode the class that won last is moved to the bottom of the order. In fixed mode only, a waiting class above the owner's class causes the arbiter to pull an active-low bus-clear output. The owner must end its tenure while bus-clear is low.

If all masters are placed in one class, the block behaves as a plain chained-grant arbiter.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: After reset, no class grant or slot grant is active, and bus_clear_n is high.
- R2: A class asks for the bus whenever any of its slots has its slot_req bit set (bit c*SLOTS_PER_CLASS+s belongs to slot s of class c). A new class grant appears only on the clock edge that samples bus_busy low, and it is visible from that edge onward.
- R3: At most one class_grant bit and at most one slot_grant bit are high in any cycle.
- R4: In fixed mode (rotate_mode low), the requesting class with the highest index receives the grant.
- R5: In rotating mode, the search starts at the class just below the last granted class and wraps downward, so the last winner has the lowest priority. Before any grant, the order matches fixed mode.
- R6: Within the granted class, the requesting slot with the lowest index gets slot_grant. chain_tail for that class is high only when no slot of the class is requesting.
- R7: While bus_busy is high, class_grant does not change.
- R8: In fixed mode, while the owner holds bus_busy high and some class above the owner's class requests, bus_clear_n goes low on the next edge and stays low until release. In rotating mode, bus_clear_n is never newly pulled low.
- R9: On the edge that samples bus_busy low during a clear, bus_clear_n returns high and the grant moves to the winning pending class on that same edge.
- R10: If the granted class stops requesting before bus_busy has been raised, the grant is withdrawn on the next edge, and arbitration restarts on the edge after that.
- R11: When only one class has requesting slots, the chain position alone picks the master, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rotate_mode | input | 1 | 1 selects the rotating class policy, 0 selects fixed priority |
| slot_req | input | NUM_CLASSES*SLOTS_PER_CLASS | Bus wanted, one bit per master slot |
| bus_busy | input | 1 | Driven high by the master that currently owns the bus |
| class_grant | output | NUM_CLASSES | Grant line for each class (one-hot or zero) |
| slot_grant | output | NUM_CLASSES*SLOTS_PER_CLASS | Grant taken by a slot on its chain |
| chain_tail | output | NUM_CLASSES | Grant that passed the end of a class chain untaken |
| bus_clear_n | output | 1 | Active-low request for the owner to release the bus |

## Verification
A corrupted owner or last-winner register appears at the ports on the first arbitration that follows. A wrong owner gives a wrong class_grant or a spurious bus_clear_n one edge after a higher class requests. A stale rotation pointer sends the next grant to the wrong class. A controller stuck in the wrong phase holds a grant past a release, or moves a grant while bus_busy is high, and this is visible on the very next edge. A fault in the chain shows in the same cycle as a second slot_grant bit or a missing one.

// File: rtl/hyb_arb_pkg.sv
package hyb_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_OWNED = 2'd2,
        ST_CLEAR = 2'd3
    } arb_state_e;

endpackage

// File: rtl/hyb_class_pick.sv
module hyb_class_pick #(
    parameter  int NC = 4,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic [NC-1:0] req,
    input  logic          rotate,
    input  logic [CW-1:0] last_idx,
    output logic          win_vld,
    output logic [CW-1:0] win_idx,
    output logic [NC-1:0] win_oh
);

    // Search order: fixed mode walks NC-1 down to 0; rotating mode walks
    // downward from the class below the last winner, wrapping around.
    always_comb begin
        int cand;
        cand    = 0;
        win_vld = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= NC; k++) begin
            cand = rotate ? ((int'(last_idx) + NC - k) % NC) : (NC - k);
            if (!win_vld && req[cand]) begin
                win_vld = 1'b1;
                win_idx = CW'(cand);
            end
        end
    end

    assign win_oh = win_vld ? (NC'(1) << win_idx) : '0;

endmodule

// File: rtl/hyb_daisy_chain.sv
module hyb_daisy_chain #(
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_in,
    input  logic [SLOTS-1:0] req,
    output logic [SLOTS-1:0] gnt_out,
    output logic             pass_out
);

    logic [SLOTS:0] link;

    assign link[0] = grant_in;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign gnt_out[i]  = link[i] & req[i];
        assign link[i+1]   = link[i] & ~req[i];
    end

    assign pass_out = link[SLOTS];

    // R3
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_out));

    // R6
    slot_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_out != '0) |-> (grant_in && (((gnt_out - SLOTS'(1)) & req) == '0)));

    // R6
    tail_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_out |-> (grant_in && (req == '0)));

endmodule

// File: rtl/hybrid_bus_arbiter.sv
module hybrid_bus_arbiter #(
    parameter  int NUM_CLASSES     = 4,
    parameter  int SLOTS_PER_CLASS = 4,
    localparam int NS              = NUM_CLASSES * SLOTS_PER_CLASS,
    localparam int CW              = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rotate_mode,
    input  logic [NS-1:0]          slot_req,
    input  logic                   bus_busy,
    output logic [NUM_CLASSES-1:0] class_grant,
    output logic [NS-1:0]          slot_grant,
    output logic [NUM_CLASSES-1:0] chain_tail,
    output logic                   bus_clear_n
);
    import hyb_arb_pkg::*;

    typedef struct packed {
        arb_state_e             st;
        logic [NUM_CLASSES-1:0] gnt;
        logic [CW-1:0]          owner;
        logic [CW-1:0]          last;
        logic                   clr;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [NUM_CLASSES-1:0] cls_req;
    logic                   win_vld;
    logic [CW-1:0]          win_idx;
    logic [NUM_CLASSES-1:0] win_oh;
    logic                   above_owner;
    logic                   arbitrate;

    // Wired request per class: any slot of the class wants the bus.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        assign cls_req[c] = |slot_req[c*SLOTS_PER_CLASS +: SLOTS_PER_CLASS];

        hyb_daisy_chain #(
            .SLOTS (SLOTS_PER_CLASS)
        ) u_chain (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant_in (cur_q.gnt[c]),
            .req      (slot_req[c*SLOTS_PER_CLASS +: SLOTS_PER_CLASS]),
            .gnt_out  (slot_grant[c*SLOTS_PER_CLASS +: SLOTS_PER_CLASS]),
            .pass_out (chain_tail[c])
        );
    end

    hyb_class_pick #(
        .NC (NUM_CLASSES)
    ) u_pick (
        .req      (cls_req),
        .rotate   (rotate_mode),
        .last_idx (cur_q.last),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_oh   (win_oh)
    );

    // Is a class ranked above the owner waiting?
    always_comb begin
        above_owner = 1'b0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (cls_req[c] && (c > int'(cur_q.owner))) begin
                above_owner = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_d     = cur_q;
        arbitrate = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                arbitrate = !bus_busy;
            end
            ST_OFFER: begin
                if (bus_busy) begin
                    nxt_d.st = ST_OWNED;
                end else if (!cls_req[cur_q.owner]) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.gnt = '0;
                end
            end
            ST_OWNED: begin
                if (!bus_busy) begin
                    arbitrate = 1'b1;
                end else if (!rotate_mode && above_owner) begin
                    nxt_d.st  = ST_CLEAR;
                    nxt_d.clr = 1'b1;
                end
            end
            ST_CLEAR: begin
                arbitrate = !bus_busy;
            end
            default: begin
                nxt_d.st  = ST_IDLE;
                nxt_d.gnt = '0;
                nxt_d.clr = 1'b0;
            end
        endcase

        if (arbitrate) begin
            nxt_d.clr = 1'b0;
            if (win_vld) begin
                nxt_d.st    = ST_OFFER;
                nxt_d.gnt   = win_oh;
                nxt_d.owner = win_idx;
                nxt_d.last  = win_idx;
            end else begin
                nxt_d.st  = ST_IDLE;
                nxt_d.gnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.gnt   <= '0;
            cur_q.owner <= '0;
            cur_q.last  <= '0;
            cur_q.clr   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign class_grant = cur_q.gnt;
    assign bus_clear_n = ~cur_q.clr;

    // R3
    class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(class_grant));

    // R2
    grant_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((class_grant != '0) && (class_grant != $past(class_grant))) |-> !$past(bus_busy));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((class_grant != '0) && bus_busy) |=> (class_grant == $past(class_grant)));

    // R4
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate_mode && win_vld) |-> ((cls_req >> win_idx) == NUM_CLASSES'(1)));

    // R5
    rotate_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_mode && win_vld && (cls_req != (NUM_CLASSES'(1) << cur_q.last)))
            |-> (win_idx != cur_q.last));

    // R8
    no_clear_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate_mode && bus_clear_n) |=> bus_clear_n);

    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_clear_n && !bus_busy) |=> bus_clear_n);

endmodule

// File: tb/hybrid_bus_arbiter_tb.sv
module hybrid_bus_arbiter_tb;

    localparam int CLK_P = 10;
    localparam int NC    = 4;
    localparam int S     = 4;
    localparam int NS    = NC * S;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rot_v = 1'b0;
    logic [NS-1:0] req_v = '0;
    logic          busy_v = 1'b0;
    logic [NC-1:0] class_grant;
    logic [NS-1:0] slot_grant;
    logic [NC-1:0] chain_tail;
    logic          bus_clear_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model of the expected behaviour.
    int m_st   = 0;   // 0 idle, 1 offered, 2 owned, 3 clearing
    int m_gnt  = -1;
    int m_last = 0;
    bit m_clr  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hybrid_bus_arbiter #(
        .NUM_CLASSES     (NC),
        .SLOTS_PER_CLASS (S)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rotate_mode (rot_v),
        .slot_req    (req_v),
        .bus_busy    (busy_v),
        .class_grant (class_grant),
        .slot_grant  (slot_grant),
        .chain_tail  (chain_tail),
        .bus_clear_n (bus_clear_n)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NC-1:0] class_wants(input logic [NS-1:0] r);
        logic [NC-1:0] w;
        w = '0;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < S; s++)
                if (r[c*S+s]) w[c] = 1'b1;
        return w;
    endfunction

    function automatic int pick(input logic [NC-1:0] w, input bit rot, input int last);
        for (int k = 1; k <= NC; k++) begin
            int c;
            c = rot ? ((last + NC - k) % NC) : (NC - k);
            if (w[c]) return c;
        end
        return -1;
    endfunction

    task automatic model_step();
        logic [NC-1:0] w;
        bit above;
        bit arb;
        int win;
        w = class_wants(req_v);
        above = 1'b0;
        for (int c = 0; c < NC; c++) if (w[c] && c > m_gnt) above = 1'b1;
        arb = 1'b0;
        case (m_st)
            0: arb = !busy_v;
            1: if (busy_v) m_st = 2;
               else if (!w[m_gnt]) begin m_st = 0; m_gnt = -1; end
            2: if (!busy_v) arb = 1'b1;
               else if (!rot_v && above) begin m_st = 3; m_clr = 1'b1; end
            default: if (!busy_v) arb = 1'b1;
        endcase
        if (arb) begin
            m_clr = 1'b0;
            win = pick(w, rot_v, m_last);
            if (win >= 0) begin m_st = 1; m_gnt = win; m_last = win; end
            else begin m_st = 0; m_gnt = -1; end
        end
    endtask

    task automatic compare_all(input string tag);
        logic [NC-1:0] eg;
        logic [NS-1:0] es;
        logic [NC-1:0] et;
        eg = '0; es = '0; et = '0;
        if (m_gnt >= 0) begin
            int hit;
            hit = -1;
            eg[m_gnt] = 1'b1;
            for (int s = S - 1; s >= 0; s--) if (req_v[m_gnt*S+s]) hit = s;
            if (hit >= 0) es[m_gnt*S+hit] = 1'b1;
            else et[m_gnt] = 1'b1;
        end
        chk(32'(class_grant), 32'(eg), tag);
        chk(32'(slot_grant), 32'(es), "R6");
        chk(32'(chain_tail), 32'(et), "R6");
        chk(32'(bus_clear_n), 32'(!m_clr), "R8");
        chk(32'($countones(class_grant) <= 1 && $countones(slot_grant) <= 1), 32'd1, "R3");
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL R1: watchdog expired, actual running expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0047));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(32'(class_grant), 32'd0, "R1");
        chk(32'(slot_grant), 32'd0, "R1");
        chk(32'(bus_clear_n), 32'd1, "R1");
        rst_n = 1'b1;

        // R2: bus held busy, no grant may appear
        busy_v = 1'b1;
        req_v  = 16'h0040;
        repeat (3) cycle("R2");
        chk(32'(class_grant), 32'd0, "R2");

        // R4 and R6: fixed mode, classes 1 and 2 requesting
        busy_v = 1'b0;
        req_v  = 16'h0A40;
        cycle("R4");
        chk(32'(class_grant), 32'h4, "R4");
        chk(32'(slot_grant), 32'h0200, "R6");

        // R7: owner busy, lower class arrives
        busy_v = 1'b1;
        req_v  = 16'h0A41;
        repeat (2) cycle("R7");
        chk(32'(class_grant), 32'h4, "R7");

        // R8: higher class arrives in fixed mode
        req_v = 16'h1A41;
        cycle("R8");
        chk(32'(bus_clear_n), 32'd0, "R8");
        chk(32'(class_grant), 32'h4, "R7");
        cycle("R8");
        chk(32'(bus_clear_n), 32'd0, "R8");

        // R9: owner releases, pending top class granted at once
        busy_v = 1'b0;
        cycle("R9");
        chk(32'(bus_clear_n), 32'd1, "R9");
        chk(32'(class_grant), 32'h8, "R9");
        chk(32'(slot_grant), 32'h1000, "R9");

        // R10: offered class withdraws before taking the bus
        req_v = 16'h0A41;
        cycle("R10");
        chk(32'(class_grant), 32'h0, "R10");
        cycle("R10");
        chk(32'(class_grant), 32'h4, "R10");

        // R5: rotating mode, last winner is class 2
        rot_v  = 1'b1;
        busy_v = 1'b1; cycle("R5");
        busy_v = 1'b0; cycle("R5");
        chk(32'(class_grant), 32'h2, "R5");
        busy_v = 1'b1; cycle("R5");
        req_v  = 16'h1A41;
        cycle("R8");
        chk(32'(bus_clear_n), 32'd1, "R8");
        busy_v = 1'b0; cycle("R5");
        chk(32'(class_grant), 32'h1, "R5");
        busy_v = 1'b1; cycle("R5");
        busy_v = 1'b0; cycle("R5");
        chk(32'(class_grant), 32'h8, "R5");

        // R11: only class 0 slots requesting, both modes
        busy_v = 1'b1; req_v = 16'h0006; cycle("R11");
        busy_v = 1'b0; cycle("R11");
        chk(32'(class_grant), 32'h1, "R11");
        chk(32'(slot_grant), 32'h0002, "R11");
        rot_v = 1'b0;
        busy_v = 1'b1; cycle("R11");
        req_v = 16'h0004; busy_v = 1'b0; cycle("R11");
        chk(32'(slot_grant), 32'h0004, "R11");

        // Random traffic against the bench model
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < NS; b++)
                if ($urandom_range(7) == 0) req_v[b] = ~req_v[b];
            if ($urandom_range(63) == 0) rot_v = ~rot_v;
            if (busy_v) begin
                if ($urandom_range(3) == 0 || (m_clr && $urandom_range(1) == 0))
                    busy_v = 1'b0;
            end else if (m_st == 1 && $urandom_range(1) == 0) begin
                busy_v = 1'b1;
            end
            cycle("R5");
        end

        summary();
    end

endmodule